// File: doc/BRIEF.md
# Multiplexed GPIO Port with Mode-Dependent Readback

An 8-bit general-purpose I/O port. Each pin works in one of three ways: as a plain input, as a plain output driven from the port data register, or as an output owned by one of two serial channels. Per-bit direction and secondary-function registers choose the mode. The block drives the pad output value and the pad output enable. It samples the pad inputs through a synchronizer. It passes conditioned pin values on to the serial channels, and it returns a mode-dependent value when the CPU reads the port data address.

The CPU side is a plain single-cycle register bus. It has a 2-bit address, a write strobe and write data, and a combinational read-data output. It has no valid/ready handshake and never back-pressures: a write is always accepted at the next rising clock edge, and read data follows the address within the same cycle. A read-modify-write is an ordinary read of the data address, a change made by the CPU, and a write back to the same address.

Pin 3 carries the clock of serial channel 4. It drives its pad only when a separate clock-drive enable is also set. A polarity control inverts this pin on both its input path and its output path.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, pad_oe is 0, and the data, direction, secondary-function and auxiliary registers all read 0.
- R2: For a bit whose direction bit is 0, a read of address 0 returns the synchronized pad state, whatever its secondary-function bit holds. For pin 3 this value passes through the polarity inversion.
- R3: For a bit with direction 1 and secondary-function 0, the pad is driven with the data register bit, and a read of address 0 returns that register bit.
- R4: With direction 1 and secondary-function 1, pin 0 drives and reads back ser3_clk, pin 2 uses ser3_dout, and pin 4 uses ser4_dout.
- R5: With direction 1 and secondary-function 1, pins 1 and 5 read back 0 at address 0, while their pads keep driving the data register bit.
- R6: A read-modify-write of address 0 uses the mode-dependent read value as its operand, and the result lands in the data register.
- R7: pad_oe[3] is 1 only when direction bit 3 and auxiliary bit 0 (clock drive enable) are both 1. For every other pin, pad_oe equals its direction bit.
- R8: Auxiliary bit 1 (clock invert) inverts pin 3 on pad_out[3], on pin_cond[3] and on input-mode reads. In secondary output mode, pin 3 drives ser4_clk XOR invert and reads back ser4_clk without inversion.
- R9: pin_cond and pin-state reads follow pad_in two clock edges late.
- R10: The registers sit at these addresses: 0 is data, 1 is direction, 2 is secondary-function, and 3 is auxiliary (bits 1:0; upper bits read 0). A write takes effect on the clock edge that samples bus_we. Addresses 1 to 3 read back as stored.
- R11: Pins 6 and 7 are plain GPIO: their secondary-function bits have no effect on drive or readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| ser3_clk | input | 1 | Channel 3 clock output |
| ser3_dout | input | 1 | Channel 3 data output |
| ser4_clk | input | 1 | Channel 4 clock output |
| ser4_dout | input | 1 | Channel 4 data output |
| pin_cond | output | 8 | Synchronized pins to the channels, pin 3 polarity-adjusted |

## Verification
The bench builds the block with WIDTH of 8 and SYNC_STAGES of 2. At these values all six pins that have a secondary role are present, as are the two plain pins 6 and 7, so every readback variant can be reached. The two-edge lag can also be observed exactly. Random register writes and random pad and channel values cover every combination of direction, secondary function, clock enable and polarity. Directed cases isolate the forced-zero pins, the gated clock pin, a read-modify-write, and the lag.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_SEL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_AUX  = 2'd3;

  localparam int CLK_PIN     = 3;
  localparam int AUX_W       = 2;
  localparam int AUX_CLK_OE  = 0;
  localparam int AUX_CLK_INV = 1;

  typedef enum logic [2:0] {
    ALT_NONE, ALT_ZERO, ALT_CLK3, ALT_DAT3, ALT_CLK4, ALT_DAT4
  } alt_src_e;

  typedef struct packed {
    logic dat4;
    logic clk4;
    logic dat3;
    logic clk3;
  } ser_out_t;

  // Secondary role of each pin position
  function automatic alt_src_e alt_src(int idx);
    case (idx)
      0:       return ALT_CLK3;
      1:       return ALT_ZERO;
      2:       return ALT_DAT3;
      3:       return ALT_CLK4;
      4:       return ALT_DAT4;
      5:       return ALT_ZERO;
      default: return ALT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  sel_q,
  output logic [AUX_W-1:0]  aux_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      sel_q  <= '0;
      aux_q  <= '0;
    end else if (we) begin
      case (addr)
        A_DATA:  data_q <= wdata;
        A_DIR:   dir_q  <= wdata;
        A_SEL:   sel_q  <= wdata;
        default: aux_q  <= wdata[AUX_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic     dir,
  input  logic     sel,
  input  logic     dat,
  input  logic     pin,
  input  logic     inv,
  input  logic     clk_oe,
  input  ser_out_t ser,
  output logic     pad_o,
  output logic     oe_o,
  output logic     rd_o,
  output logic     cond_o
);
  localparam alt_src_e SRC    = alt_src(IDX);
  localparam bit       IS_CLK = (IDX == CLK_PIN);

  logic alt_val, alt_act, drive_alt, drv, flip;

  always_comb begin
    case (SRC)
      ALT_CLK3: alt_val = ser.clk3;
      ALT_DAT3: alt_val = ser.dat3;
      ALT_CLK4: alt_val = ser.clk4;
      ALT_DAT4: alt_val = ser.dat4;
      default:  alt_val = 1'b0;
    endcase
  end

  assign flip      = IS_CLK ? inv : 1'b0;
  assign alt_act   = dir & sel & (SRC != ALT_NONE);
  // input-only secondary roles keep the pad on the data register
  assign drive_alt = alt_act & (SRC != ALT_ZERO);
  assign drv       = drive_alt ? alt_val : dat;
  assign pad_o     = drv ^ flip;
  assign oe_o      = IS_CLK ? (dir & clk_oe) : dir;
  assign cond_o    = pin ^ flip;
  assign rd_o      = !dir ? cond_o : (alt_act ? alt_val : dat);
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic              ser3_clk,
  input  logic              ser3_dout,
  input  logic              ser4_clk,
  input  logic              ser4_dout,
  output logic [WIDTH-1:0]  pin_cond
);
  logic [WIDTH-1:0] data_q, dir_q, sel_q, pin_sync, rd_bits;
  logic [AUX_W-1:0] aux_q;
  ser_out_t         ser;

  assign ser = '{dat4: ser4_dout, clk4: ser4_clk, dat3: ser3_dout, clk3: ser3_clk};

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .sel_q(sel_q), .aux_q(aux_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_mux #(.IDX(i)) u_mux (
      .dir(dir_q[i]), .sel(sel_q[i]), .dat(data_q[i]), .pin(pin_sync[i]),
      .inv(aux_q[AUX_CLK_INV]), .clk_oe(aux_q[AUX_CLK_OE]), .ser(ser),
      .pad_o(pad_out[i]), .oe_o(pad_oe[i]), .rd_o(rd_bits[i]), .cond_o(pin_cond[i])
    );
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rd_bits;
      A_DIR:   bus_rdata = dir_q;
      A_SEL:   bus_rdata = sel_q;
      default: bus_rdata = {{(WIDTH-AUX_W){1'b0}}, aux_q};
    endcase
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_in,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pin_cond,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  sel_q,
  input logic [AUX_W-1:0]  aux_q
);
  localparam logic [WIDTH-1:0] M3 = WIDTH'(1) << CLK_PIN;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] hist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else begin
      hist[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) hist[s] <= hist[s-1];
    end
  end

  always @(posedge clk) begin
    if (!rst_n)
      p_reset_quiet_r1: assert (pad_oe == '0 && dir_q == '0 && sel_q == '0 && aux_q == '0);
  end

  p_input_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DATA) |-> ((bus_rdata & ~dir_q) == (pin_cond & ~dir_q)));

  p_forced_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DATA && dir_q[1] && sel_q[1]) |-> !bus_rdata[1]);

  p_clk_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[CLK_PIN] |-> (dir_q[CLK_PIN] && aux_q[AUX_CLK_OE]));

  p_dir_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIR) |=> ((pad_oe & ~M3) == ($past(bus_wdata) & ~M3)));

  p_sync_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_cond & ~M3) == (hist[SYNC_STAGES-1] & ~M3)));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
  .pin_cond(pin_cond), .dir_q(dir_q), .sel_q(sel_q), .aux_q(aux_q)
);

// File: tb/gpio_mux_port_test.sv
module gpio_mux_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pin_cond;
  logic       ser3_clk = 0, ser3_dout = 0, ser4_clk = 0, ser4_dout = 0;

  int errors = 0;
  int checks = 0;
  logic [7:0] sh_data = 0, sh_dir = 0, sh_sel = 0;
  logic [1:0] sh_aux = 0;

  always #2 clk = ~clk;

  gpio_mux_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .ser3_clk(ser3_clk), .ser3_dout(ser3_dout),
    .ser4_clk(ser4_clk), .ser4_dout(ser4_dout), .pin_cond(pin_cond)
  );

  function automatic logic alt_of(int k);
    case (k)
      0: return ser3_clk;
      2: return ser3_dout;
      3: return ser4_clk;
      4: return ser4_dout;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_cond();
    logic [7:0] v = pad_in;
    v[3] = pad_in[3] ^ sh_aux[1];
    return v;
  endfunction

  function automatic logic [7:0] exp_read();
    logic [7:0] v;
    logic [7:0] c = exp_cond();
    for (int k = 0; k < 8; k++) begin
      if (!sh_dir[k]) v[k] = c[k];
      else if (sh_sel[k] && k < 6) v[k] = alt_of(k);
      else v[k] = sh_data[k];
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_pad();
    logic [7:0] v;
    for (int k = 0; k < 8; k++) begin
      if (sh_dir[k] && sh_sel[k] && (k == 0 || k == 2 || k == 3 || k == 4)) v[k] = alt_of(k);
      else v[k] = sh_data[k];
    end
    v[3] = v[3] ^ sh_aux[1];
    return v;
  endfunction

  function automatic logic [7:0] exp_oe();
    logic [7:0] v = sh_dir;
    v[3] = sh_dir[3] & sh_aux[0];
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      2'd0: sh_data = d;
      2'd1: sh_dir = d;
      2'd2: sh_sel = d;
      default: sh_aux = d[1:0];
    endcase
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    rd(2'd0, v);
    chk({tag, " R2 R3 R4 R5 R8 R11 read"}, v, exp_read());
    chk({tag, " R3 R4 R8 pad_out"}, pad_out, exp_pad());
    chk({tag, " R7 pad_oe"}, pad_oe, exp_oe());
    chk({tag, " R8 R9 pin_cond"}, pin_cond, exp_cond());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, old;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd2, v); chk("R1 sel", v, 8'h00);
    rd(2'd3, v); chk("R1 aux", v, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    dir_data_chk: begin
      wr(2'd1, 8'hFF);
      rd(2'd0, v); chk("R1 data", v, 8'h00);
    end

    // R10 register readback
    wr(2'd2, 8'h5A); rd(2'd2, v); chk("R10 sel readback", v, 8'h5A);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R10 aux readback", v, 8'h03);
    wr(2'd3, 8'h00);

    // R5 forced zero pins keep driving data
    wr(2'd0, 8'h22); wr(2'd1, 8'h22); wr(2'd2, 8'h22);
    rd(2'd0, v);
    chk("R5 read", v & 8'h22, 8'h00);
    chk("R5 pad", pad_out & 8'h22, 8'h22);

    // R11 plain pins ignore secondary bits
    wr(2'd0, 8'h80); wr(2'd1, 8'hC0); wr(2'd2, 8'hC0);
    rd(2'd0, v);
    chk("R11 read", v & 8'hC0, 8'h80);
    chk("R11 pad", pad_out & 8'hC0, 8'h80);

    // R7 clock pin needs the extra enable
    wr(2'd2, 8'h00); wr(2'd1, 8'h08); wr(2'd3, 8'h00);
    chk("R7 gated", pad_oe & 8'h08, 8'h00);
    wr(2'd3, 8'h01);
    chk("R7 enabled", pad_oe & 8'h08, 8'h08);

    // R8 inversion of the clock pin
    wr(2'd1, 8'h00); wr(2'd3, 8'h02);
    pad_in = 8'h08; settle();
    rd(2'd0, v); chk("R8 input read", v & 8'h08, 8'h00);
    chk("R8 pin_cond", pin_cond & 8'h08, 8'h00);
    ser4_clk = 1'b1;
    wr(2'd1, 8'h08); wr(2'd2, 8'h08); wr(2'd3, 8'h03);
    chk("R8 pad inverted", pad_out & 8'h08, 8'h00);
    rd(2'd0, v); chk("R8 readback uninverted", v & 8'h08, 8'h08);

    // R9 two-edge lag
    wr(2'd1, 8'h00); wr(2'd3, 8'h00);
    pad_in = 8'h00; settle();
    old = pin_cond;
    pad_in = 8'hA5;
    @(negedge clk); chk("R9 after one edge", pin_cond, old);
    @(negedge clk); chk("R9 after two edges", pin_cond, 8'hA5);

    // R6 read-modify-write
    wr(2'd0, 8'h00); wr(2'd1, 8'h0F); wr(2'd2, 8'h05);
    pad_in = 8'hF0; ser3_clk = 1; ser3_dout = 0; settle();
    rd(2'd0, v); chk("R6 operand", v, 8'hF1);
    wr(2'd0, v | 8'h02);
    wr(2'd1, 8'hFF); wr(2'd2, 8'h00);
    rd(2'd0, v); chk("R6 result", v, 8'hF3);

    // random sweep
    for (int it = 0; it < 400; it++) begin
      logic [7:0] s = 8'($urandom);
      wr(2'($urandom), 8'($urandom));
      pad_in = 8'($urandom);
      {ser3_clk, ser3_dout, ser4_clk, ser4_dout} = s[3:0];
      settle();
      check_all("rand");
      rd(2'd1, v); chk("R10 dir", v, sh_dir);
      rd(2'd2, v); chk("R10 sel", v, sh_sel);
      rd(2'd3, v); chk("R10 aux", v, {6'd0, sh_aux});
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule